// File: doc/BRIEF.md
# Vector Byte Permute Unit

This block rearranges the bytes of 128-bit vectors. Two source vectors, `srcA` and `srcB`, are joined into a 32-byte pool. Each result byte is then picked from any position in that pool. In its general mode a third vector supplies one selection index per result byte, so the block acts as a full byte crossbar.

The fixed rearrangements are produced by the same crossbar. These are interleaving the upper or lower halves of both sources, extracting a byte-aligned window from the pair, and replicating one element. The only difference between modes is where the indices come from: a small decoder builds them from the mode code and the immediate.

An operation is presented for one cycle with `inValid` high. Its result is registered and appears on the next clock edge with `outValid`. The unit accepts a new operation every cycle.

Top module: `vperm_unit`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `result` is all zeros.
- R2: An operation accepted with `inValid` high is reported one clock edge later, with `outValid` high in that cycle. In a cycle that follows an edge where `inValid` was low, `outValid` is low.
- R3: When `inValid` is low at an edge, `result` keeps its previous value.
- R4: Mode 0 (permute): byte 0 of a vector is bits 127:120 and byte 15 is bits 7:0. The pool is the bytes of `srcA` (pool 0–15) followed by the bytes of `srcB` (pool 16–31). Result byte i equals the pool byte indexed by the low 5 bits of `ctrl` byte i. The upper 3 bits of each `ctrl` byte have no effect.
- R5: Modes 1, 2 and 3 (merge-high at 8, 16 and 32 bits) fill the result with alternating elements. Elements at even positions come from `srcA` and elements at odd positions come from `srcB`. Both are taken in order from the low-numbered half of each source. For example, byte merge-high uses pool indices 0,16,1,17,…,7,23.
- R6: Modes 4, 5 and 6 (merge-low at 8, 16 and 32 bits) interleave in the same way as R5, but take elements from the high-numbered half of each source (byte merge-low: 8,24,…,15,31).
- R7: Mode 7 (align): result byte i equals pool byte i+s, where s = `imm[3:0]`. `imm[4]` has no effect.
- R8: Modes 8, 9 and 10 (splat at 8, 16 and 32 bits) copy element e of `srcA` into every element of the result. Here e is `imm[3:0]` for bytes, `imm[2:0]` for halfwords and `imm[1:0]` for words. Higher immediate bits have no effect.
- R9: Mode codes 11 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| mode | input | 4 | Operation code (see R4–R9) |
| imm | input | 5 | Shift amount or element number |
| srcA | input | 128 | First source vector (pool bytes 0–15) |
| srcB | input | 128 | Second source vector (pool bytes 16–31) |
| ctrl | input | 128 | Per-byte selection indices for permute mode |
| outValid | output | 1 | Result registered from an operation |
| result | output | 128 | Rearranged vector |

## Verification
The bench builds the unit with its default of 16 lanes. This gives a 32-entry pool indexed by 5 bits, so every index is reachable: the extreme align shift of 15 with `imm[4]` set, the last element of each splat granularity, and control bytes whose upper bits are set. With source bytes equal to their own pool numbers, each expected result doubles as a readable map of the indices the decoder produced. Randomised permutes and back-to-back issue then exercise the crossbar and the one-cycle pipeline.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  typedef enum logic [3:0] {
    MODE_PERM  = 4'd0,
    MODE_MHB   = 4'd1,
    MODE_MHH   = 4'd2,
    MODE_MHW   = 4'd3,
    MODE_MLB   = 4'd4,
    MODE_MLH   = 4'd5,
    MODE_MLW   = 4'd6,
    MODE_ALIGN = 4'd7,
    MODE_SPB   = 4'd8,
    MODE_SPH   = 4'd9,
    MODE_SPW   = 4'd10
  } permMode_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic capture;
    logic zeroOut;
  } permStrobe_t;

endpackage

// File: rtl/vperm_ctrl.sv
module vperm_ctrl
  import vperm_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  parameter int IDX_W     = $clog2(2 * NUM_BYTES),
  parameter int IMM_W     = $clog2(NUM_BYTES) + 1
) (
  input  logic                       inValid,
  input  logic [3:0]                 mode,
  input  logic [IMM_W-1:0]           imm,
  input  logic [NUM_BYTES*8-1:0]     ctrl,
  output permStrobe_t                strobe,
  output logic [NUM_BYTES*IDX_W-1:0] idxVec
);

  localparam int SH_W = $clog2(NUM_BYTES);
  localparam int HALF = NUM_BYTES / 2;

  // pool index for merge lanes; lane i counts from the most significant byte
  function automatic int mergeIdx(int lane, int grain, int lowHalf);
    int elem;
    int off;
    int base;
    elem = lane / (2 * grain);
    off  = lane % (2 * grain);
    base = elem * grain + (lowHalf != 0 ? HALF : 0);
    if (off < grain) return base + off;
    return NUM_BYTES + base + off - grain;
  endfunction

  always_comb begin
    strobe.capture = inValid;
    strobe.zeroOut = (mode > MODE_SPW);
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    localparam logic [IDX_W-1:0] MHB = IDX_W'(mergeIdx(i, 1, 0));
    localparam logic [IDX_W-1:0] MHH = IDX_W'(mergeIdx(i, 2, 0));
    localparam logic [IDX_W-1:0] MHW = IDX_W'(mergeIdx(i, 4, 0));
    localparam logic [IDX_W-1:0] MLB = IDX_W'(mergeIdx(i, 1, 1));
    localparam logic [IDX_W-1:0] MLH = IDX_W'(mergeIdx(i, 2, 1));
    localparam logic [IDX_W-1:0] MLW = IDX_W'(mergeIdx(i, 4, 1));
    localparam logic [IDX_W-1:0] LANE = IDX_W'(i);
    localparam logic [IDX_W-1:0] IN2  = IDX_W'(i % 2);
    localparam logic [IDX_W-1:0] IN4  = IDX_W'(i % 4);

    logic [IDX_W-1:0] laneIdx;
    logic [IDX_W-1:0] splatH;
    logic [IDX_W-1:0] splatW;

    always_comb begin
      splatH = IDX_W'({imm[SH_W-2:0], 1'b0}) + IN2;
      splatW = IDX_W'({imm[SH_W-3:0], 2'b00}) + IN4;
      case (mode)
        MODE_PERM:  laneIdx = ctrl[(NUM_BYTES-1-i)*8 +: IDX_W];
        MODE_MHB:   laneIdx = MHB;
        MODE_MHH:   laneIdx = MHH;
        MODE_MHW:   laneIdx = MHW;
        MODE_MLB:   laneIdx = MLB;
        MODE_MLH:   laneIdx = MLH;
        MODE_MLW:   laneIdx = MLW;
        MODE_ALIGN: laneIdx = LANE + IDX_W'(imm[SH_W-1:0]);
        MODE_SPB:   laneIdx = IDX_W'(imm[SH_W-1:0]);
        MODE_SPH:   laneIdx = splatH;
        MODE_SPW:   laneIdx = splatW;
        default:    laneIdx = '0;
      endcase
    end

    assign idxVec[i*IDX_W +: IDX_W] = laneIdx;
  end

endmodule

// File: rtl/vperm_dp.sv
module vperm_dp
  import vperm_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  parameter int IDX_W     = $clog2(2 * NUM_BYTES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  permStrobe_t                strobe,
  input  logic [NUM_BYTES*8-1:0]     srcA,
  input  logic [NUM_BYTES*8-1:0]     srcB,
  input  logic [NUM_BYTES*IDX_W-1:0] idxVec,
  output logic [NUM_BYTES*8-1:0]     result,
  output logic                       outValid
);

  localparam int VEC_W  = NUM_BYTES * 8;
  localparam int POOL_N = 2 * NUM_BYTES;

  logic [7:0]       pool [POOL_N];
  logic [VEC_W-1:0] nextRes;

  for (genvar j = 0; j < NUM_BYTES; j++) begin : g_pool
    assign pool[j]             = srcA[(NUM_BYTES-1-j)*8 +: 8];
    assign pool[NUM_BYTES + j] = srcB[(NUM_BYTES-1-j)*8 +: 8];
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_xbar
    assign nextRes[(NUM_BYTES-1-i)*8 +: 8] = pool[idxVec[i*IDX_W +: IDX_W]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        result <= strobe.zeroOut ? '0 : nextRes;
      end
    end
  end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  localparam int VEC_W = NUM_BYTES * 8,
  localparam int IDX_W = $clog2(2 * NUM_BYTES),
  localparam int IMM_W = $clog2(NUM_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       mode,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] ctrl,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);

  permStrobe_t                strobe;
  logic [NUM_BYTES*IDX_W-1:0] idxVec;

  vperm_ctrl #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_ctrl (
    .inValid(inValid),
    .mode   (mode),
    .imm    (imm),
    .ctrl   (ctrl),
    .strobe (strobe),
    .idxVec (idxVec)
  );

  vperm_dp #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcA    (srcA),
    .srcB    (srcB),
    .idxVec  (idxVec),
    .result  (result),
    .outValid(outValid)
  );

endmodule

// File: rtl/vperm_chk.sv
module vperm_chk #(
  parameter int NUM_BYTES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic [3:0]             mode,
  input logic                   outValid,
  input logic [NUM_BYTES*8-1:0] result
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode > 4'd10) |=> (result == '0));

  // R8
  splat_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 4'd8) |=> (result == {NUM_BYTES{result[7:0]}}));

endmodule

bind vperm_unit vperm_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .mode    (mode),
  .outValid(outValid),
  .result  (result)
);

// File: tb/vperm_unit_bench.sv
`timescale 1ns/1ps
module vperm_unit_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [3:0]   mode = '0;
  logic [4:0]   imm = '0;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic [127:0] ctrl = '0;
  logic         outValid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  logic [127:0] expQ[$];
  string        tagQ[$];
  logic [127:0] lastExp = '0;

  always #2.5 clk = ~clk;

  vperm_unit u_vperm_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .imm(imm),
    .srcA(srcA), .srcB(srcB), .ctrl(ctrl), .outValid(outValid), .result(result)
  );

  function automatic logic [127:0] refModel(input logic [3:0] md, input logic [4:0] im,
                                            input logic [127:0] a, input logic [127:0] b,
                                            input logic [127:0] c);
    logic [7:0] pa [32];
    logic [7:0] ob [16];
    logic [127:0] r;
    for (int j = 0; j < 16; j++) begin
      pa[j]      = a[127-8*j -: 8];
      pa[16 + j] = b[127-8*j -: 8];
      ob[j]      = 8'h00;
    end
    if (md == 0) begin
      for (int i = 0; i < 16; i++) ob[i] = pa[int'(c[127-8*i -: 8]) % 32];
    end else if (md <= 6) begin
      int g;
      int nel;
      int lowOff;
      g = 1 << ((int'(md) - 1) % 3);
      nel = 16 / g;
      lowOff = (md >= 4) ? nel / 2 : 0;
      for (int e = 0; e < nel; e++) begin
        for (int k = 0; k < g; k++) begin
          if (e % 2 == 0) ob[e*g + k] = pa[(e/2 + lowOff)*g + k];
          else            ob[e*g + k] = pa[16 + (e/2 + lowOff)*g + k];
        end
      end
    end else if (md == 7) begin
      for (int i = 0; i < 16; i++) ob[i] = pa[i + int'(im) % 16];
    end else if (md <= 10) begin
      int g;
      int el;
      g = 1 << (int'(md) - 8);
      el = int'(im) % (16 / g);
      for (int i = 0; i < 16; i++) ob[i] = pa[el*g + i % g];
    end
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = ob[i];
    return r;
  endfunction

  task automatic issue(input logic [3:0] md, input logic [4:0] im, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] c, input string tag);
    logic [127:0] e;
    @(negedge clk);
    mode = md; imm = im; srcA = a; srcB = b; ctrl = c; inValid = 1'b1;
    e = refModel(md, im, a, b, c);
    expQ.push_back(e);
    tagQ.push_back(tag);
    lastExp = e;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      srcA = {4{$urandom}};
      mode = 4'd0;
    end
  endtask

  task automatic checkVal(input logic [127:0] got, input logic [127:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // monitor: compares each reported result with the oldest expected item
  always @(posedge clk) begin
    #1;
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2 unexpected outValid got 1 exp 0");
      end else begin
        checkVal(result, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [127:0] ID_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] ID_B = 128'h101112131415161718191a1b1c1d1e1f;

  initial begin
    logic [127:0] rc;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkVal({127'd0, outValid}, 128'd0, "R1 outValid in reset");
    checkVal(result, 128'd0, "R1 result in reset");
    @(negedge clk);
    rstN = 1'b1;

    // R4 permute: reverse, identity, upper bits set
    issue(4'd0, 5'd0, ID_A, ID_B, 128'h1f1e1d1c1b1a19181716151413121110, "R4 permute reverse-B");
    issue(4'd0, 5'd0, ID_A, ID_B, 128'he0e1e2e3e4e5e6e7e8e9eaebecedeeef, "R4 ctrl upper bits ignored");
    issue(4'd0, 5'd0, ID_A, ID_B, 128'h00100f1f011e020d031c040b051a0609, "R4 mixed indices");
    idle(2);
    for (int t = 0; t < 6; t++) begin
      rc = {$urandom, $urandom, $urandom, $urandom};
      issue(4'd0, 5'd0, {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, rc, "R4 random permute");
    end
    // R5 merge high, R6 merge low
    issue(4'd1, 5'd0, ID_A, ID_B, '0, "R5 merge-high byte");
    issue(4'd2, 5'd0, ID_A, ID_B, '0, "R5 merge-high half");
    issue(4'd3, 5'd0, ID_A, ID_B, '0, "R5 merge-high word");
    issue(4'd4, 5'd0, ID_A, ID_B, '0, "R6 merge-low byte");
    issue(4'd5, 5'd0, ID_A, ID_B, '0, "R6 merge-low half");
    issue(4'd6, 5'd0, ID_A, ID_B, '0, "R6 merge-low word");
    // R7 align
    issue(4'd7, 5'd0,  ID_A, ID_B, '0, "R7 align 0");
    issue(4'd7, 5'd5,  ID_A, ID_B, '0, "R7 align 5");
    issue(4'd7, 5'd31, ID_A, ID_B, '0, "R7 align 15 imm4 ignored");
    // R8 splat
    issue(4'd8,  5'd0,  ID_A, ID_B, '0, "R8 splat byte 0");
    issue(4'd8,  5'd31, ID_A, ID_B, '0, "R8 splat byte 15 high imm");
    issue(4'd9,  5'd7,  ID_A, ID_B, '0, "R8 splat half 7");
    issue(4'd9,  5'd26, ID_A, ID_B, '0, "R8 splat half high imm");
    issue(4'd10, 5'd3,  ID_A, ID_B, '0, "R8 splat word 3");
    issue(4'd10, 5'd29, ID_A, ID_B, '0, "R8 splat word high imm");
    // R9 reserved codes
    issue(4'd11, 5'd0, ID_A, ID_B, 128'h0, "R9 reserved 11");
    issue(4'd15, 5'd3, ID_A, ID_B, 128'h0, "R9 reserved 15");
    issue(4'd7, 5'd9, ID_A, ID_B, '0, "R7 align 9 before hold");
    idle(4);
    // R3 hold and R2 flag low while idle
    checkVal(result, lastExp, "R3 result held while idle");
    checkVal({127'd0, outValid}, 128'd0, "R2 outValid low while idle");
    checkVal(128'(expQ.size()), 128'd0, "R2 every operation reported");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule